// File: doc/BRIEF.md
# Asynchronous SRAM Control Decode Core

This block is a storage array with the pins of a classic asynchronous static RAM. It has an address bus, a byte-wide data path split into a data-in port, a data-out port and a drive-enable flag that stands in for the three-state bus, two chip selects of opposite polarity, an active-low output enable and an active-low write enable. Each clock edge samples the control pins and decodes them into one of four modes: deselected, output disabled, read, or write. The block stores or returns a word for that mode and updates a power-down status flag.

The system clock stands in for the asynchronous timing of a real device. A write commits at the edge where it is sampled. Read data follows the presented address one cycle later, together with the drive enable. The address width is a parameter. The default is kept small so that elaboration stays light, and setting `ADDR_W` to 17 gives the full 131,072-word by 8-bit array. Reset clears only the control registers. The array keeps its contents through reset, deselection and power-down.

Top module: `sram_async_core`

## Requirements
- R1: The part counts as selected only when `ce1_n` is 0 and `ce2` is 1. Every other pair of chip-select levels is a deselect.
- R2: At a clock edge where the part is selected and `we_n` is 0, the word on `din` is stored at the location on `addr`.
- R3: At a clock edge where the part is selected with `we_n` = 1 and `oe_n` = 0, the next cycle shows `drive_en` = 1 and `dout` equal to the word stored at the sampled address.
- R4: Write has priority over output enable. After a selected edge with `we_n` = 0, `drive_en` is 0 in the next cycle for either level of `oe_n`.
- R5: `drive_en` is 0 in the cycle after an edge where the part is deselected, or where it is selected with `oe_n` = 1.
- R6: `dout` is all zeros in every cycle in which `drive_en` is 0.
- R7: `pwr_down` is 1 in the cycle after an edge that samples a deselect, and 0 in the cycle after an edge that samples a selection.
- R8: While reset is held and just after it is released, `drive_en` is 0 and `pwr_down` is 1. Reset does not alter the stored words.
- R9: No location changes at an edge where the part is deselected or `we_n` is 1. Words stay intact across any length of power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control registers |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| dout | output | DATA_W | Read data, zero while not driving |
| drive_en | output | 1 | Bus drive enable; 0 stands for high impedance |
| pwr_down | output | 1 | Power-down status, high while deselected |

## Verification
The power-down flag release and a write commit fall on the same edge when a write is presented in the first cycle after a deselect. The bench provokes this by holding the part deselected for several cycles and then applying a write directly. In the following cycle it checks that `pwr_down` has cleared and `drive_en` is still low, and a later read confirms the word was stored. A second case places a read in the cycle right after a write to the same address. The registered read must return the newly committed word.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
   typedef enum logic [1:0] {
      MODE_DESEL  = 2'd0,
      MODE_OUTOFF = 2'd1,
      MODE_READ   = 2'd2,
      MODE_WRITE  = 2'd3
   } sram_mode_e;
endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
   import sram_ctl_pkg::*;
(
   input  logic       ce1_n,
   input  logic       ce2,
   input  logic       oe_n,
   input  logic       we_n,
   output sram_mode_e mode
);
   logic selected;
   assign selected = !ce1_n && ce2;

   // write beats output enable; output enable only matters for reads
   always_comb begin
      if (!selected)  mode = MODE_DESEL;
      else if (!we_n) mode = MODE_WRITE;
      else if (!oe_n) mode = MODE_READ;
      else            mode = MODE_OUTOFF;
   end
endmodule

// File: rtl/sram_store.sv
module sram_store #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   // array has no reset; read port is registered and follows the address
   always_ff @(posedge clk) begin
      if (wr_en) cells[addr] <= wdata;
      rdata <= cells[addr];
   end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
   import sram_ctl_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sram_mode_e        mode,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] dout,
   output logic              drive_en,
   output logic              pwr_down
);
   logic drive_q;
   logic pd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= 1'b0;
         pd_q    <= 1'b1;
      end else begin
         drive_q <= (mode == MODE_READ);
         pd_q    <= (mode == MODE_DESEL);
      end
   end

   assign drive_en = drive_q;
   assign pwr_down = pd_q;

   generate
      if (PARK_ZERO) begin : g_park
         assign dout = drive_q ? rdata : '0;
      end else begin : g_pass
         assign dout = rdata;
      end
   endgenerate
endmodule

// File: rtl/sram_async_core.sv
module sram_async_core
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              ce1_n,
   input  logic              ce2,
   input  logic              oe_n,
   input  logic              we_n,
   output logic [DATA_W-1:0] dout,
   output logic              drive_en,
   output logic              pwr_down
);
   generate
      if (ADDR_W < 1 || ADDR_W > 17) begin : g_bad_aw
         $error("sram_async_core: ADDR_W must lie in 1..17");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_dw
         $error("sram_async_core: DATA_W must lie in 1..64");
      end
   endgenerate

   sram_mode_e        mode;
   logic [DATA_W-1:0] rdata;

   sram_mode_decode u_dec (
      .ce1_n (ce1_n),
      .ce2   (ce2),
      .oe_n  (oe_n),
      .we_n  (we_n),
      .mode  (mode)
   );

   sram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .wr_en (mode == MODE_WRITE),
      .addr  (addr),
      .wdata (din),
      .rdata (rdata)
   );

   sram_out_stage #(.DATA_W(DATA_W), .PARK_ZERO(1'b1)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .rdata    (rdata),
      .dout     (dout),
      .drive_en (drive_en),
      .pwr_down (pwr_down)
   );
endmodule

// File: rtl/sram_async_core_chk.sv
module sram_async_core_chk #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce1_n,
   input logic              ce2,
   input logic              oe_n,
   input logic              we_n,
   input logic [DATA_W-1:0] dout,
   input logic              drive_en,
   input logic              pwr_down
);
   // R4
   write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce1_n && ce2 && !we_n) |=> !drive_en);

   // R5
   desel_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ce1_n && ce2) |=> !drive_en);

   // R5
   oe_off_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce1_n && ce2 && oe_n) |=> !drive_en);

   // R3
   read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce1_n && ce2 && we_n && !oe_n) |=> drive_en);

   // R7
   pd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ce1_n && ce2) |=> pwr_down);

   // R7
   pd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce1_n && ce2) |=> !pwr_down);

   // R6
   park_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_en |-> (dout == '0));
endmodule

bind sram_async_core sram_async_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce1_n    (ce1_n),
   .ce2      (ce2),
   .oe_n     (oe_n),
   .we_n     (we_n),
   .dout     (dout),
   .drive_en (drive_en),
   .pwr_down (pwr_down)
);

// File: tb/tb_sram_async_core.sv
module tb_sram_async_core;
   localparam int AW = 11;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic          ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
   logic [DW-1:0] dout;
   logic          drive_en, pwr_down;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sram_async_core #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
      .ce1_n(ce1_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n),
      .dout(dout), .drive_en(drive_en), .pwr_down(pwr_down)
   );

   // {ce1_n, ce2, oe_n, we_n, exp_drive, exp_pd, exp_write}, index = control bits
   localparam logic [6:0] VEC [16] = '{
      7'b0000_010, 7'b0001_010, 7'b0010_010, 7'b0011_010,
      7'b0100_001, 7'b0101_100, 7'b0110_001, 7'b0111_000,
      7'b1000_010, 7'b1001_010, 7'b1010_010, 7'b1011_010,
      7'b1100_010, 7'b1101_010, 7'b1110_010, 7'b1111_010
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive pins after a falling edge, then let one rising edge sample them
   task automatic step(input logic [3:0] ctl, input logic [AW-1:0] a, input logic [DW-1:0] d);
      {ce1_n, ce2, oe_n, we_n} = ctl;
      addr = a;
      din  = d;
      @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      step(4'b0100, a, d);
   endtask

   task automatic rd(input logic [AW-1:0] a);
      step(4'b0101, a, '0);
   endtask

   logic [DW-1:0] pat [32];

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8 state during reset
      check("R8 drive_en in reset", drive_en, 0);
      check("R8 pwr_down in reset", pwr_down, 1);
      rst_n = 1'b1;
      step(4'b1000, '0, '0);
      check("R8 drive_en after reset", drive_en, 0);
      check("R8 pwr_down after reset", pwr_down, 1);

      // Table walk: every control combination (R1 R2 R3 R4 R5 R6 R7 R9)
      for (int i = 0; i < 16; i++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] oldv, newv;
         a    = AW'(i * 37 + 5);
         oldv = DW'(8'hA0 ^ i);
         newv = DW'(8'h5C ^ (i << 3));
         wr(a, oldv);
         step(VEC[i][6:3], a, newv);
         check("R1/R4/R5 drive_en per control combo", drive_en, VEC[i][2]);
         check("R1/R7 pwr_down per control combo", pwr_down, VEC[i][1]);
         check("R3/R6 dout per control combo", dout, VEC[i][2] ? oldv : 8'h00);
         rd(a);
         check("R2/R9 stored word per control combo", dout, VEC[i][0] ? newv : oldv);
      end

      // R2 R3 random patterns, write all then read all
      begin
         logic [7:0] lf = 8'h1D;
         for (int k = 0; k < 32; k++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            pat[k] = lf;
            wr(AW'(k * 61 + 900), lf);
         end
         for (int k = 0; k < 32; k++) begin
            rd(AW'(k * 61 + 900));
            check("R3 random read-back", dout, pat[k]);
            check("R3 drive_en during read", drive_en, 1);
         end
      end

      // R9 long power-down keeps data
      for (int c = 0; c < 6; c++) step(4'b1101, AW'(900), 8'hFF);
      check("R7 pwr_down held while deselected", pwr_down, 1);
      check("R6 dout parked while deselected", dout, 0);
      // write in the first cycle after deselect: pd release and commit together
      wr(AW'(77), 8'hC3);
      check("R7 pwr_down clears on write after deselect", pwr_down, 0);
      check("R4 no drive on write after deselect", drive_en, 0);
      rd(AW'(77));
      check("R2 word from write after deselect", dout, 8'hC3);
      rd(AW'(900));
      check("R9 word kept over power-down", dout, pat[0]);

      // read right after write to the same address
      wr(AW'(300), 8'h96);
      rd(AW'(300));
      check("R3 read after write same address", dout, 8'h96);
      // read then write: drive drops at once
      step(4'b0110, AW'(300), 8'h69);
      check("R4 drive drops on write with oe_n high", drive_en, 0);
      rd(AW'(300));
      check("R2 write with oe_n high stored", dout, 8'h69);

      // R8 reset keeps array
      rst_n = 1'b0;
      @(negedge clk);
      check("R8 drive_en in mid-run reset", drive_en, 0);
      check("R8 pwr_down in mid-run reset", pwr_down, 1);
      rst_n = 1'b1;
      rd(AW'(300));
      check("R8 word kept across reset", dout, 8'h69);
      check("R1 selection after reset clears pwr_down", pwr_down, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule